// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a serial slave on a two-wire SMBus/I2C-style bus. It gives a host read and write access to a bank of byte-wide configuration registers, for example output-enable bits. The register contents drive a parallel output bus. Every register comes out of reset with a fixed default, so a system that never touches the bus still gets a usable configuration.

The host opens a transaction with a start condition and the device address. The next byte is a command byte. Its top bit picks single-byte access or block access, two chip-select bits must be zero, and the low five bits give the register offset used by single-byte access. Block access always starts at register 0 and walks upward. A block write carries a byte count before its data. A block read first returns the bank size as a count and then returns the registers in order. The slave samples SCL and SDA on the system clock through synchronizers. It only ever pulls SDA low and never drives SCL.

Top module: `smbus_cfg_slave`

## Requirements
- R1: After reset, register i holds 0xA0 OR i (register 0 = 0xA0, register 31 = 0xBF) and the SDA pull-down is released.
- R2: The slave acknowledges an address byte only when its upper seven bits equal 0x69 (0xD2 to write, 0xD3 to read). On any other address it leaves SDA released for the rest of the transaction and changes no register.
- R3: A command byte with bit 7 = 1 selects single-byte access at the offset in bits 4:0. One following data byte is written to that register, and a read after a repeated start returns that register's value, most significant bit first.
- R4: A command byte with bit 7 = 0 selects block access. The slave acknowledges the byte count that follows, then writes each data byte to registers 0, 1, 2, ... in order and acknowledges each one.
- R5: In a block read, the first byte the slave returns is the bank size, 0x20. It then returns registers 0, 1, 2, ... for as long as the host acknowledges, and stops driving after the host's not-acknowledge.
- R6: If command bits 6:5 are not 00, the slave does not acknowledge the command and ignores all bytes until the next start. A read address that follows such a command is also not acknowledged.
- R7: Block-write data bytes beyond register 31 are acknowledged but change no register. The write pointer does not wrap.
- R8: In single-byte mode, a second data byte after the first is not acknowledged and is not written.
- R9: A start or stop condition in the middle of a byte abandons the transfer. After a start the slave expects a fresh address byte.
- R10: The slave changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | When high, the open-drain driver pulls SDA low |
| regs_o | output | NREG*8 | Register bank contents, register i at bits 8i+7:8i |

## Verification
The bench drives the bus bit by bit as a host would, with SDA modelled as a wired-AND of host and slave. The main read/write function is tried with single-byte writes and reads at a mid-bank offset, a short block write followed by a block read, and a full-bank block write one byte longer than the bank. These runs separate offset decoding from the block pointer, show that the count byte comes before the data, and show that the pointer saturates at the top of the bank instead of wrapping. Further runs use a foreign address, a non-zero chip-select field, an extra byte after a single-byte write, and bytes cut off by a stop or start. These confirm that refused traffic leaves SDA released and the registers unchanged.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int BYTE_W       = 8;
  localparam int CMD_MODE_BIT = 7;
  localparam int CMD_CS_HI    = 6;
  localparam int CMD_CS_LO    = 5;
  localparam int CMD_OFF_W    = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_TX,
    ST_IGNORE
  } smb_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } smb_phase_e;

  // fixed power-up value of register idx
  function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
    return 8'hA0 | 8'(idx & 31);
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edges while the clock line stays high
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter  int NREG  = 32,
  localparam int PTR_W = $clog2(NREG) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [PTR_W-1:0]       waddr,
  input  logic [BYTE_W-1:0]      wdata,
  input  logic [PTR_W-1:0]       raddr,
  output logic [BYTE_W-1:0]      rdata,
  output logic [NREG*BYTE_W-1:0] regs_flat
);

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= reg_default(g);
        else if (we && waddr == PTR_W'(g))
          q <= wdata;
      end
      assign regs_flat[g*BYTE_W +: BYTE_W] = q;
    end
  endgenerate

  // reads past the bank return zero
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr == PTR_W'(i)) rdata = regs_flat[i*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import smb_cfg_pkg::*;
#(
  parameter  int         NREG     = 32,
  parameter  logic [6:0] DEV_ADDR = 7'h69,
  localparam int         PTR_W    = $clog2(NREG) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [PTR_W-1:0]  rd_addr_o
);

  localparam logic [PTR_W-1:0]  PTR_END = PTR_W'(NREG);
  localparam logic [BYTE_W-1:0] CNT_VAL = BYTE_W'(NREG);

  smb_state_e        state_q, nxt_q;
  smb_phase_e        phase_q;
  logic [3:0]        bitcnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              blk_q, cmd_ok_q, bdone_q, cnt_pend_q, host_ack_q;
  logic              pull_q, we_q;
  logic [PTR_W-1:0]  waddr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic [BYTE_W-1:0] tx_byte;
  logic              ptr_in_bank;

  assign tx_byte     = cnt_pend_q ? CNT_VAL : rd_data;
  assign ptr_in_bank = (ptr_q < PTR_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      nxt_q      <= ST_RX;
      phase_q    <= PH_ADDR;
      bitcnt_q   <= '0;
      sh_q       <= '0;
      ptr_q      <= '0;
      blk_q      <= 1'b1;
      cmd_ok_q   <= 1'b0;
      bdone_q    <= 1'b0;
      cnt_pend_q <= 1'b0;
      host_ack_q <= 1'b0;
      pull_q     <= 1'b0;
      we_q       <= 1'b0;
      waddr_q    <= '0;
      wdata_q    <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_p) begin
        state_q  <= ST_RX;
        phase_q  <= PH_ADDR;
        bitcnt_q <= '0;
        pull_q   <= 1'b0;
      end else if (stop_p) begin
        state_q  <= ST_IDLE;
        pull_q   <= 1'b0;
        cmd_ok_q <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise && bitcnt_q < 4'd8) begin
              sh_q     <= {sh_q[BYTE_W-2:0], sda_s};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              case (phase_q)
                PH_ADDR: begin
                  if (sh_q[7:1] == DEV_ADDR && (!sh_q[0] || cmd_ok_q)) begin
                    pull_q     <= 1'b1;
                    bitcnt_q   <= 4'd9;
                    nxt_q      <= sh_q[0] ? ST_TX : ST_RX;
                    phase_q    <= PH_CMD;
                    cnt_pend_q <= blk_q;
                  end else begin
                    state_q <= ST_IGNORE;
                  end
                end
                PH_CMD: begin
                  if (sh_q[CMD_CS_HI:CMD_CS_LO] == 2'b00) begin
                    pull_q   <= 1'b1;
                    bitcnt_q <= 4'd9;
                    nxt_q    <= ST_RX;
                    blk_q    <= ~sh_q[CMD_MODE_BIT];
                    ptr_q    <= sh_q[CMD_MODE_BIT] ? PTR_W'(sh_q[CMD_OFF_W-1:0]) : '0;
                    cmd_ok_q <= 1'b1;
                    bdone_q  <= 1'b0;
                    phase_q  <= sh_q[CMD_MODE_BIT] ? PH_DATA : PH_CNT;
                  end else begin
                    cmd_ok_q <= 1'b0;
                    state_q  <= ST_IGNORE;
                  end
                end
                PH_CNT: begin
                  // count value is not needed to place the data
                  pull_q   <= 1'b1;
                  bitcnt_q <= 4'd9;
                  nxt_q    <= ST_RX;
                  phase_q  <= PH_DATA;
                end
                default: begin
                  if (!blk_q && bdone_q) begin
                    state_q <= ST_IGNORE;
                  end else begin
                    pull_q   <= 1'b1;
                    bitcnt_q <= 4'd9;
                    nxt_q    <= ST_RX;
                    bdone_q  <= 1'b1;
                    if (ptr_in_bank) begin
                      we_q    <= 1'b1;
                      waddr_q <= ptr_q;
                      wdata_q <= sh_q;
                      ptr_q   <= ptr_q + 1'b1;
                    end
                  end
                end
              endcase
            end else if (scl_fall && bitcnt_q == 4'd9) begin
              bitcnt_q <= '0;
              state_q  <= nxt_q;
              if (nxt_q == ST_TX) begin
                sh_q   <= tx_byte;
                pull_q <= ~tx_byte[7];
                if (cnt_pend_q) cnt_pend_q <= 1'b0;
                else if (ptr_in_bank) ptr_q <= ptr_q + 1'b1;
              end else begin
                pull_q <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              if (bitcnt_q < 4'd8) begin
                bitcnt_q <= bitcnt_q + 4'd1;
              end else if (bitcnt_q == 4'd8) begin
                host_ack_q <= ~sda_s;
                bitcnt_q   <= 4'd9;
              end
            end else if (scl_fall) begin
              if (bitcnt_q >= 4'd1 && bitcnt_q <= 4'd7) begin
                sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                pull_q <= ~sh_q[6];
              end else if (bitcnt_q == 4'd8) begin
                pull_q <= 1'b0;
              end else if (bitcnt_q == 4'd9) begin
                if (host_ack_q) begin
                  bitcnt_q <= '0;
                  sh_q     <= tx_byte;
                  pull_q   <= ~tx_byte[7];
                  if (cnt_pend_q) cnt_pend_q <= 1'b0;
                  else if (ptr_in_bank) ptr_q <= ptr_q + 1'b1;
                end else begin
                  pull_q  <= 1'b0;
                  state_q <= ST_IGNORE;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_en_o    = we_q;
  assign wr_addr_o  = waddr_q;
  assign wr_data_o  = wdata_q;
  assign rd_addr_o  = ptr_q;

  // R10
  sda_low_only_chk: assert property (@(posedge clk) disable iff (rst)
    (pull_q != $past(pull_q)) |-> !$past(scl_s));

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGNORE) |-> !pull_q);

  // R4
  write_in_low_chk: assert property (@(posedge clk) disable iff (rst)
    we_q |-> !scl_s);

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_p |=> (state_q == ST_RX && phase_q == PH_ADDR && bitcnt_q == 4'd0));

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> (state_q == ST_IDLE && !pull_q));

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int         NREG        = 32,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pull_o,
  output logic [NREG*BYTE_W-1:0] regs_o
);

  localparam int PTR_W = $clog2(NREG) + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  smb_slave_fsm #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_p    (start_p),
    .stop_p     (stop_p),
    .rd_data    (rd_data),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .rd_addr_o  (rd_addr)
  );

  smb_reg_bank #(.NREG(NREG)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_en),
    .waddr     (wr_addr),
    .wdata     (wr_data),
    .raddr     (rd_addr),
    .rdata     (rd_data),
    .regs_flat (regs_o)
  );

endmodule

// File: tb/smbus_cfg_slave_test.sv
module smbus_cfg_slave_test;

  localparam int Q    = 6;
  localparam int NREG = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hscl = 1'b1;
  logic hsda = 1'b1;
  logic sda_pull;
  logic [NREG*8-1:0] regs_o;
  logic sda_line;

  int nchk = 0;
  int nerr = 0;
  int r10_bad = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic [7:0] val;
  } exp_t;
  exp_t       exp_q[$];
  logic [7:0] act_q[$];

  always #2 clk = ~clk;

  assign sda_line = hsda & ~sda_pull;

  smbus_cfg_slave uut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (hscl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .regs_o     (regs_o)
  );

  // scoreboard monitor
  initial begin
    exp_t e;
    logic [7:0] a;
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        e = exp_q.pop_front();
        a = act_q.pop_front();
        nchk++;
        if (a !== e.val) begin
          nerr++;
          $display("FAIL %s: got %02h expected %02h", e.req, a, e.val);
        end
      end
    end
  end

  // R10 watcher: pull-down must hold still while SCL stays high
  logic prev_scl = 1'b1;
  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (!rst && prev_scl && hscl && sda_pull !== prev_pull) r10_bad++;
    prev_scl  <= hscl;
    prev_pull <= sda_pull;
  end

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    hsda = 1'b1; tick();
    hscl = 1'b1; tick();
    hsda = 1'b0; tick();
    hscl = 1'b0; tick();
  endtask

  task automatic bus_stop();
    hsda = 1'b0; tick();
    hscl = 1'b1; tick();
    hsda = 1'b1; tick();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      hsda = b[i]; tick();
      hscl = 1'b1; tick(); tick();
      hscl = 1'b0; tick();
    end
  endtask

  task automatic wr(input logic [7:0] b, input string req, input bit ack_exp);
    exp_t e;
    send_bits(b, 8);
    hsda = 1'b1; tick();
    hscl = 1'b1; tick();
    e.req = req; e.val = {7'd0, ack_exp};
    exp_q.push_back(e);
    act_q.push_back({7'd0, ~sda_line});
    tick();
    hscl = 1'b0; tick();
  endtask

  task automatic rd(input logic [7:0] exp_v, input string req, input bit host_ack);
    exp_t e;
    logic [7:0] v;
    v = '0;
    hsda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      hscl = 1'b1; tick();
      v = {v[6:0], sda_line};
      tick();
      hscl = 1'b0;
    end
    tick();
    e.req = req; e.val = exp_v;
    exp_q.push_back(e);
    act_q.push_back(v);
    hsda = host_ack ? 1'b0 : 1'b1; tick();
    hscl = 1'b1; tick(); tick();
    hscl = 1'b0; tick();
    hsda = 1'b1;
  endtask

  task automatic chk_reg(input int idx, input logic [7:0] e, input string req);
    nchk++;
    if (regs_o[idx*8 +: 8] !== e) begin
      nerr++;
      $display("FAIL %s: reg%0d got %02h expected %02h", req, idx, regs_o[idx*8 +: 8], e);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk_reg(0, 8'hA0, "R1");
    chk_reg(31, 8'hBF, "R1");
    nchk++;
    if (sda_pull !== 1'b0) begin
      nerr++;
      $display("FAIL R1: sda_pull got %b expected 0", sda_pull);
    end

    // R3 single-byte write to offset 5
    bus_start();
    wr(8'hD2, "R2", 1'b1);
    wr(8'h85, "R3", 1'b1);
    wr(8'h3C, "R3", 1'b1);
    bus_stop();
    chk_reg(5, 8'h3C, "R3");
    chk_reg(4, 8'hA4, "R3");

    // R3 single-byte read back
    bus_start();
    wr(8'hD2, "R2", 1'b1);
    wr(8'h85, "R3", 1'b1);
    bus_start();
    wr(8'hD3, "R2", 1'b1);
    rd(8'h3C, "R3", 1'b0);
    bus_stop();

    // R2 foreign address
    bus_start();
    wr(8'hA4, "R2", 1'b0);
    wr(8'h80, "R2", 1'b0);
    wr(8'h11, "R2", 1'b0);
    bus_stop();
    chk_reg(0, 8'hA0, "R2");

    // R4 block write of three bytes
    bus_start();
    wr(8'hD2, "R4", 1'b1);
    wr(8'h00, "R4", 1'b1);
    wr(8'h03, "R4", 1'b1);
    wr(8'h11, "R4", 1'b1);
    wr(8'h22, "R4", 1'b1);
    wr(8'h33, "R4", 1'b1);
    bus_stop();
    chk_reg(0, 8'h11, "R4");
    chk_reg(1, 8'h22, "R4");
    chk_reg(2, 8'h33, "R4");
    chk_reg(3, 8'hA3, "R4");

    // R5 block read: count then data
    bus_start();
    wr(8'hD2, "R5", 1'b1);
    wr(8'h00, "R5", 1'b1);
    bus_start();
    wr(8'hD3, "R5", 1'b1);
    rd(8'h20, "R5", 1'b1);
    rd(8'h11, "R5", 1'b1);
    rd(8'h22, "R5", 1'b1);
    rd(8'h33, "R5", 1'b1);
    rd(8'hA3, "R5", 1'b0);
    bus_stop();

    // R6 non-zero chip select
    bus_start();
    wr(8'hD2, "R6", 1'b1);
    wr(8'hA7, "R6", 1'b0);
    wr(8'h55, "R6", 1'b0);
    bus_stop();
    chk_reg(7, 8'hA7, "R6");
    bus_start();
    wr(8'hD2, "R6", 1'b1);
    wr(8'hC7, "R6", 1'b0);
    bus_start();
    wr(8'hD3, "R6", 1'b0);
    bus_stop();

    // R7 block write one byte longer than the bank
    bus_start();
    wr(8'hD2, "R7", 1'b1);
    wr(8'h00, "R7", 1'b1);
    wr(8'd33, "R7", 1'b1);
    for (int i = 0; i < 33; i++)
      wr(8'(i) ^ 8'h5A, (i == 32) ? "R7" : "R4", 1'b1);
    bus_stop();
    chk_reg(0, 8'h5A, "R7");
    chk_reg(31, 8'h45, "R7");
    chk_reg(16, 8'h4A, "R4");

    // R8 extra byte after single-byte write
    bus_start();
    wr(8'hD2, "R8", 1'b1);
    wr(8'h8A, "R8", 1'b1);
    wr(8'h77, "R8", 1'b1);
    wr(8'h99, "R8", 1'b0);
    bus_stop();
    chk_reg(10, 8'h77, "R8");
    chk_reg(11, 8'h51, "R8");

    // R9 stop in the middle of a command byte
    bus_start();
    wr(8'hD2, "R9", 1'b1);
    send_bits(8'h81, 4);
    bus_stop();
    chk_reg(1, 8'h5B, "R9");
    bus_start();
    wr(8'hD2, "R9", 1'b1);
    wr(8'h81, "R9", 1'b1);
    wr(8'hEE, "R9", 1'b1);
    bus_stop();
    chk_reg(1, 8'hEE, "R9");

    // R9 start in the middle of a command byte
    bus_start();
    wr(8'hD2, "R9", 1'b1);
    send_bits(8'hFF, 3);
    bus_start();
    wr(8'hD2, "R9", 1'b1);
    wr(8'h82, "R9", 1'b1);
    wr(8'h44, "R9", 1'b1);
    bus_stop();
    chk_reg(2, 8'h44, "R9");
    chk_reg(1, 8'hEE, "R9");

    // R10 pull-down never moved while SCL was high
    nchk++;
    if (r10_bad != 0) begin
      nerr++;
      $display("FAIL R10: changes during SCL high got %0d expected 0", r10_bad);
    end

    repeat (10) @(negedge clk);
    if (exp_q.size() != 0) begin
      nchk++;
      nerr++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    report();
  end

endmodule